// File: doc/BRIEF.md
# Delta-Panel Horizontal Timing Generator

This block drives the horizontal side of an active-matrix display whose colour dots are laid out in a delta pattern and whose column shift register is built into the glass. It runs from a clock at twice the shift-register bit rate, so one clock cycle (a tick) is half a bit period. A one-cycle line-sync pulse starts each line. A one-cycle field-start pulse marks the first line of a field. From these the block produces a shift-register start pulse, a pair of complementary shift clocks, a blanking flag, a per-line video polarity flag, a scan-direction output and a colour-channel swap select.

On a delta panel the dots that share one column line are offset by one and a half dots on neighbouring rows. The start pulse and the shift-clock phase therefore move back and forth by three ticks (1.5 bits) from line to line. Each shift-clock edge advances the panel register by one stage. The number of stages clocked per line follows the latched aspect mode: 357 in wide mode and 269 in narrow mode. The aspect and direction inputs are static controls. They are only taken in on field start.

Top module: `delta_htiming_gen`

## Requirements
- R1: `hck2` is always the inverse of `hck1`. Each level of `hck1` lasts exactly 2 ticks, so one bit period is 2 ticks and a shift-clock period is 4 ticks. Both clocks run continuously, and line sync re-phases them only when it occurs.
- R2: Each line carries exactly one `hst` pulse. It is 4 ticks wide, and `hck1` rises 2 ticks after `hst` rises, at the middle of the pulse.
- R3: When `line_sync` is sampled high at clock edge k, `hst` goes high after edge k+LEAD on an even line and after edge k+LEAD+3 on an odd line. This is a 1.5-bit shift of the start pulse and of the clock phase.
- R4: Line parity alternates on every line sync. A field start resets it, so the first line of a field is always even. A field start and a line sync in the same cycle make that line even.
- R5: `blank` is low for exactly 2·N+2 ticks per line, starting with the `hst` rise. N is 357 when the latched aspect bit is 1 (wide) and 269 when it is 0 (narrow).
- R6: `blank` goes high on the cycle after a line sync. It stays high until `hst` rises, and again from the end of the active window until the next line's start pulse.
- R7: `vid_pol` inverts after every line sync, across field boundaries too, and holds its value otherwise.
- R8: `wide_sel` and `scan_right` are captured only on a cycle with `field_start` high. A change at any other time has no effect on `blank`, `dir_right` or `swap_23`.
- R9: `dir_right` equals the latched `scan_right` (1 = right/normal scan). `swap_23` is its inverse and selects the swapped phase order of colour channels 2 and 3 for left scan.
- R10: After reset, `hst`=0, `blank`=1, `hck1`=0, `hck2`=1, `vid_pol`=0 and `dir_right`=1, the latched aspect is wide, and the next line is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_sync | input | 1 | One-cycle pulse starting a line |
| field_start | input | 1 | One-cycle pulse marking the first line of a field |
| wide_sel | input | 1 | Aspect select, 1 = wide (357 stages), 0 = narrow (269 stages) |
| scan_right | input | 1 | Direction select, 1 = right scan, 0 = left scan |
| hst | output | 1 | Shift-register start pulse |
| hck1 | output | 1 | Shift clock, phase 1 |
| hck2 | output | 1 | Shift clock, phase 2 |
| blank | output | 1 | High outside the active stage window |
| vid_pol | output | 1 | Video polarity, inverts every line |
| dir_right | output | 1 | Latched scan direction |
| swap_23 | output | 1 | Colour channel 2/3 phase swap select |

## Verification
The case hardest to reach from the ports is a parity reset that lands on an odd-numbered line. The stimulus reaches it by issuing a lone `field_start` pulse in the blank tail of an odd line's predecessor, so the next line would otherwise have taken the 3-tick offset. A mode change in the middle of a field is also awkward: the new aspect must stay invisible until the next field start. The stimulus flips both mode inputs partway through a field and measures the active window length on every later line. A behavioural model tracks tick positions as integers and is compared with the outputs on every cycle. Per-line tallies check the start delay, the pulse count and the window length.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;
    // latched per-field controls plus per-line flags
    typedef struct packed {
        logic wide;
        logic right;
        logic par;
        logic pol;
    } field_state_t;

    localparam int unsigned HALF_BIT_OFS = 3; // 1.5 bit periods in ticks
    localparam int unsigned HST_TICKS    = 4; // one shift-clock period
endpackage

// File: rtl/hdrv_field_ctl.sv
module hdrv_field_ctl
    import hdrv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_sync,
    input  logic field_start,
    input  logic wide_sel,
    input  logic scan_right,
    output logic wide_q,
    output logic right_q,
    output logic odd_line,
    output logic pol_q
);
    field_state_t st_d, st_q;
    logic         par_eff;

    always_comb begin
        st_d    = st_q;
        par_eff = field_start ? 1'b0 : st_q.par;
        if (field_start) begin
            st_d.wide  = wide_sel;
            st_d.right = scan_right;
            st_d.par   = 1'b0;
        end
        if (line_sync) begin
            st_d.par = ~par_eff;
            st_d.pol = ~st_q.pol;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{wide: 1'b1, right: 1'b1, par: 1'b0, pol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wide_q   = st_q.wide;
    assign right_q  = st_q.right;
    assign odd_line = par_eff;
    assign pol_q    = st_q.pol;
endmodule

// File: rtl/hdrv_line_cnt.sv
module hdrv_line_cnt
    import hdrv_pkg::*;
#(
    parameter int unsigned LEAD  = 8,
    parameter int unsigned W     = 12,
    parameter int unsigned SAT   = 716
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_sync,
    input  logic                odd_line,
    output logic signed [W-1:0] pos,
    output logic                hck_ph
);
    localparam logic signed [W-1:0] SAT_S      = W'(SAT);
    localparam logic signed [W-1:0] START_EVEN = W'(-$signed(LEAD));
    localparam logic signed [W-1:0] START_ODD  = W'(-$signed(LEAD + HALF_BIT_OFS));

    typedef struct packed {
        logic signed [W-1:0] pos;
        logic [1:0]          ph;
    } line_state_t;

    line_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = st_q.ph + 2'd1;
        if (line_sync) begin
            if (odd_line) begin
                st_d.pos = START_ODD;
                st_d.ph  = START_ODD[1:0];
            end else begin
                st_d.pos = START_EVEN;
                st_d.ph  = START_EVEN[1:0];
            end
        end else if (st_q.pos < SAT_S) begin
            st_d.pos = st_q.pos + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{pos: SAT_S, ph: 2'd0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos    = st_q.pos;
    assign hck_ph = st_q.ph[1];
endmodule

// File: rtl/hdrv_decode.sv
module hdrv_decode
    import hdrv_pkg::*;
#(
    parameter int unsigned N_WIDE   = 357,
    parameter int unsigned N_NARROW = 269,
    parameter int unsigned W        = 12
) (
    input  logic signed [W-1:0] pos,
    input  logic                hck_ph,
    input  logic                wide,
    output logic                hst,
    output logic                hck1,
    output logic                hck2,
    output logic                blank
);
    localparam logic signed [W-1:0] ZERO     = '0;
    localparam logic signed [W-1:0] HST_LAST = W'(HST_TICKS - 1);
    localparam logic signed [W-1:0] END_WIDE = W'(2 * N_WIDE + 1);
    localparam logic signed [W-1:0] END_NARR = W'(2 * N_NARROW + 1);

    logic signed [W-1:0] win_end;

    always_comb begin
        win_end = wide ? END_WIDE : END_NARR;
        hst     = (pos >= ZERO) && (pos <= HST_LAST);
        blank   = !((pos >= ZERO) && (pos <= win_end));
        hck1    = hck_ph;
        hck2    = ~hck_ph;
    end
endmodule

// File: rtl/delta_htiming_gen.sv
module delta_htiming_gen #(
    parameter int unsigned LEAD     = 8,
    parameter int unsigned N_WIDE   = 357,
    parameter int unsigned N_NARROW = 269
) (
    input  logic clk,
    input  logic rst,
    input  logic line_sync,
    input  logic field_start,
    input  logic wide_sel,
    input  logic scan_right,
    output logic hst,
    output logic hck1,
    output logic hck2,
    output logic blank,
    output logic vid_pol,
    output logic dir_right,
    output logic swap_23
);
    localparam int unsigned N_MAX = (N_WIDE > N_NARROW) ? N_WIDE : N_NARROW;
    localparam int unsigned SAT   = 2 * N_MAX + 2;
    localparam int unsigned W     = $clog2(SAT + LEAD + 8) + 1;

    logic                wide_q, right_q, odd_line;
    logic signed [W-1:0] pos;
    logic                hck_ph;

    hdrv_field_ctl u_field (
        .clk        (clk),
        .rst        (rst),
        .line_sync  (line_sync),
        .field_start(field_start),
        .wide_sel   (wide_sel),
        .scan_right (scan_right),
        .wide_q     (wide_q),
        .right_q    (right_q),
        .odd_line   (odd_line),
        .pol_q      (vid_pol)
    );

    hdrv_line_cnt #(.LEAD(LEAD), .W(W), .SAT(SAT)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .line_sync(line_sync),
        .odd_line (odd_line),
        .pos      (pos),
        .hck_ph   (hck_ph)
    );

    hdrv_decode #(.N_WIDE(N_WIDE), .N_NARROW(N_NARROW), .W(W)) u_dec (
        .pos   (pos),
        .hck_ph(hck_ph),
        .wide  (wide_q),
        .hst   (hst),
        .hck1  (hck1),
        .hck2  (hck2),
        .blank (blank)
    );

    assign dir_right = right_q;
    assign swap_23   = ~right_q;
endmodule

// File: rtl/hdrv_checker.sv
module hdrv_checker (
    input logic clk,
    input logic rst,
    input logic line_sync,
    input logic field_start,
    input logic hst,
    input logic hck1,
    input logic hck2,
    input logic blank,
    input logic vid_pol,
    input logic dir_right
);
    a_r1_hck_complement: assert property (@(posedge clk) disable iff (rst)
        hck1 ^ hck2);
    a_r1_hck_high_two: assert property (@(posedge clk) disable iff (rst)
        (!blank && $rose(hck1)) |=> hck1);
    a_r1_hck_low_two: assert property (@(posedge clk) disable iff (rst)
        (!blank && $fell(hck1)) |=> !hck1);
    a_r2_hst_width: assert property (@(posedge clk) disable iff (rst)
        $rose(hst) |=> hst ##1 hst ##1 hst ##1 !hst);
    a_r2_hst_centered: assert property (@(posedge clk) disable iff (rst)
        $rose(hst) |=> ##1 $rose(hck1));
    a_r6_blank_ends_at_hst: assert property (@(posedge clk) disable iff (rst)
        $fell(blank) |-> $rose(hst));
    a_r6_blank_after_sync: assert property (@(posedge clk) disable iff (rst)
        line_sync |=> blank);
    a_r7_pol_flips: assert property (@(posedge clk) disable iff (rst)
        line_sync |=> (vid_pol != $past(vid_pol)));
    a_r7_pol_holds: assert property (@(posedge clk) disable iff (rst)
        !line_sync |=> $stable(vid_pol));
    a_r8_dir_holds: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> $stable(dir_right));
endmodule

bind delta_htiming_gen hdrv_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_sync  (line_sync),
    .field_start(field_start),
    .hst        (hst),
    .hck1       (hck1),
    .hck2       (hck2),
    .blank      (blank),
    .vid_pol    (vid_pol),
    .dir_right  (dir_right)
);

// File: tb/delta_htiming_gen_bench.sv
module delta_htiming_gen_bench;
    localparam int LEAD   = 8;
    localparam int NW     = 357;
    localparam int NN     = 269;
    localparam int LINE   = 800;
    localparam int SATV   = 2 * NW + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_sync = 1'b0, field_start = 1'b0, wide_sel = 1'b1, scan_right = 1'b1;
    logic hst, hck1, hck2, blank, vid_pol, dir_right, swap_23;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    delta_htiming_gen u_delta_htiming_gen (
        .clk(clk), .rst(rst), .line_sync(line_sync), .field_start(field_start),
        .wide_sel(wide_sel), .scan_right(scan_right), .hst(hst), .hck1(hck1),
        .hck2(hck2), .blank(blank), .vid_pol(vid_pol), .dir_right(dir_right),
        .swap_23(swap_23)
    );

    // behavioural model state
    int m_pos = SATV, m_ph = 0, m_par = 0, m_pol = 0, m_wid = 1, m_rgt = 1;
    int line_no = 0, exp_off = 0, exp_n = NW;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int pe, start;
        if (rst) begin
            m_pos = SATV; m_ph = 0; m_par = 0; m_pol = 0; m_wid = 1; m_rgt = 1;
        end else begin
            pe = m_par;
            if (field_start) begin
                m_wid = wide_sel; m_rgt = scan_right; pe = 0; m_par = 0;
            end
            if (line_sync) begin
                start = -(LEAD + (pe ? 3 : 0));
                m_pos = start;
                m_ph  = ((start % 4) + 4) % 4;
                m_par = !pe;
                m_pol = !m_pol;
                line_no++;
            end else begin
                if (m_pos < SATV) m_pos++;
                m_ph = (m_ph + 1) % 4;
            end
        end
    end

    // per-line tallies
    int seen_line = 0, t_in_line = 0, hst_cnt = 0, hst_at = -1, blank_lo = 0;
    int cur_off = 0, cur_n = NW;
    logic prev_hst = 1'b0;

    always @(negedge clk) begin
        int e_hst, e_blank, e_n;
        if (!rst && !done) begin
            if (line_no != seen_line) begin
                if (seen_line > 0) begin
                    chk(hst_cnt == 1, "R2 one start pulse per line", hst_cnt, 1);
                    chk(hst_at == LEAD + cur_off, "R3 R4 start delay", hst_at, LEAD + cur_off);
                    chk(blank_lo == 2 * cur_n + 2, "R5 R8 active window", blank_lo, 2 * cur_n + 2);
                end
                seen_line = line_no; t_in_line = 0; hst_cnt = 0; hst_at = -1; blank_lo = 0;
                cur_off = (m_pos == -(LEAD + 3)) ? 3 : 0;
                cur_n = m_wid ? NW : NN;
            end
            if (hst && !prev_hst) begin
                hst_cnt++;
                hst_at = t_in_line;
            end
            if (!blank) blank_lo++;
            prev_hst = hst;
            t_in_line++;

            e_n     = m_wid ? NW : NN;
            e_hst   = (m_pos >= 0 && m_pos <= 3);
            e_blank = !(m_pos >= 0 && m_pos <= 2 * e_n + 1);
            chk(hck1 == (m_ph >= 2) && hck2 == (m_ph < 2), "R1 shift clocks", hck1, (m_ph >= 2));
            chk(hst == e_hst, "R2 start pulse", hst, e_hst);
            chk(blank == e_blank, "R6 blank", blank, e_blank);
            chk(vid_pol == m_pol, "R7 polarity", vid_pol, m_pol);
            chk(dir_right == m_rgt && swap_23 == !m_rgt, "R8 R9 direction/swap", dir_right, m_rgt);
        end
    end

    task automatic run_line(input bit fs);
        @(negedge clk);
        line_sync = 1'b1; field_start = fs;
        @(negedge clk);
        line_sync = 1'b0; field_start = 1'b0;
        repeat (LINE - 1) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(hst == 0 && blank == 1, "R10 reset hst/blank", {hst, blank}, 1);
        chk(hck1 == 0 && hck2 == 1, "R10 reset clocks", {hck1, hck2}, 1);
        chk(vid_pol == 0 && dir_right == 1, "R10 reset pol/dir", {vid_pol, dir_right}, 1);
        // field 1: wide, right scan
        wide_sel = 1'b1; scan_right = 1'b1;
        run_line(1'b1);
        repeat (3) run_line(1'b0);
        // R8: change controls mid-field, must not take effect
        wide_sel = 1'b0; scan_right = 1'b0;
        repeat (2) run_line(1'b0);
        // lone field start in blank tail: parity reset before what would be an odd line (R4)
        run_line(1'b0);
        repeat (LINE / 2) @(negedge clk);
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
        repeat (3) run_line(1'b0);
        // field 3: back to wide, right
        wide_sel = 1'b1; scan_right = 1'b1;
        repeat (3) run_line(1'b0 == 1'b0);
        run_line(1'b0);
        run_line(1'b0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule